// File: doc/BRIEF.md
# Load/Store Alignment Unit

This unit sits between a processor core and a 32-bit data memory. For each load or store request it forms the effective address as a base register plus a sign-extended 16-bit displacement. It then issues one memory access for a word, halfword or byte. For stores it places the data on the write bus and raises the byte enables of the lanes being written. For loads it later takes the returned memory word, picks out the addressed halfword or byte, and extends it with sign or zeros as the opcode requires.

Accesses that are not naturally aligned are not split into two transfers. The unit raises a one-cycle exception pulse and issues no memory access at all. Byte lanes are big-endian: address offset 0 is the most significant byte of the word.

Requests are captured on a clock edge, and the memory-side outputs appear in the following cycle. A read response is captured on a clock edge, and the extended load value appears in the following cycle. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `lsu_align_unit`

## Requirements
- R1: For a load or store request, `mem_addr` equals `req_base + sign_extend(req_offset)`, wrapped modulo 2^32, in the cycle after the request is captured.
- R2: A word store (opcode 0x35) drives `mem_wdata` equal to `req_wdata` and `mem_be` = 4'b1111. `mem_be[i]` covers data bits 8i+7..8i.
- R3: A halfword store (opcode 0x36) replicates `req_wdata[15:0]` into both halves of `mem_wdata`. It drives `mem_be` = 4'b1100 when address bit 1 is 0, and 4'b0011 when address bit 1 is 1.
- R4: A byte store (opcode 0x37) replicates `req_wdata[7:0]` into all four lanes. It drives `mem_be` = 4'b1000 shifted right by the two low address bits.
- R5: Opcodes 0x30 to 0x34 are loads and 0x35 to 0x37 are stores. An aligned load raises `mem_re` with `mem_be` = 0. An aligned store raises `mem_we`. Each lasts exactly one cycle, and `mem_we` and `mem_re` are never high together.
- R6: A word load (0x30) returns the whole response word. `ld_valid` and `ld_data` follow `rsp_valid` by one cycle and use the size, sign and offset of the most recent aligned load. `ld_data` holds its value when there is no response.
- R7: Halfword loads take bits 31..16 when address bit 1 is 0, and bits 15..0 when it is 1. Opcode 0x31 sign-extends the halfword and opcode 0x32 zero-extends it.
- R8: Byte loads take the byte at address offset k from bits 31-8k..24-8k. Opcode 0x33 sign-extends the byte and opcode 0x34 zero-extends it.
- R9: A halfword access with address bit 0 set, or a word access with either of address bits 1..0 set, raises `misalign_exc` for one cycle. It keeps `mem_we`, `mem_re` and `mem_be` at 0 and does not change the latched load context.
- R10: When `req_valid` is low, or the opcode is not a load or store, the request is ignored. `mem_we`, `mem_re`, `misalign_exc` and `mem_be` stay 0, and `mem_addr` and `mem_wdata` hold their values.
- R11: During reset, `mem_we`, `mem_re`, `misalign_exc`, `ld_valid`, `mem_be`, `mem_addr`, `mem_wdata` and `ld_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 6 | Operation code |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| rsp_valid | input | 1 | Read data from memory is valid |
| rsp_rdata | input | 32 | Read data word from memory |
| mem_addr | output | 32 | Effective byte address |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_be | output | 4 | Byte write enables |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| misalign_exc | output | 1 | Alignment exception pulse |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The unit keeps a small amount of state: a latched load context of size, sign and lane offset. If that context is wrong, the error does not show when the load is issued. It shows only on the extended result, one cycle after the matching read response, so the bench puts responses at varying distances from their loads. A wrong request decode or a wrong lane computation shows at once, in the next cycle, on the strobes, the byte enables or the write bus. The reference model therefore compares every output on every clock, so that a fault is pinned to the cycle in which it first appears.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    ACC_WORD = 2'd0,
    ACC_HALF = 2'd1,
    ACC_BYTE = 2'd2
  } acc_size_e;

  localparam logic [5:0] OP_LDW  = 6'h30;
  localparam logic [5:0] OP_LDH  = 6'h31;
  localparam logic [5:0] OP_LDHU = 6'h32;
  localparam logic [5:0] OP_LDB  = 6'h33;
  localparam logic [5:0] OP_LDBU = 6'h34;
  localparam logic [5:0] OP_STW  = 6'h35;
  localparam logic [5:0] OP_STH  = 6'h36;
  localparam logic [5:0] OP_STB  = 6'h37;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int OP_W   = 6
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [DATA_W-1:0] ea,
  output logic              is_load,
  output logic              is_store,
  output acc_size_e         size,
  output logic              sign_ext,
  output logic              misaligned
);
  localparam int EXT_W = DATA_W - OFF_W;

  always_comb begin
    ea = base + {{EXT_W{offset[OFF_W-1]}}, offset};
  end

  always_comb begin
    is_load  = 1'b0;
    is_store = 1'b0;
    size     = ACC_WORD;
    sign_ext = 1'b0;
    unique case (op)
      OP_LDW:  begin is_load = 1'b1; size = ACC_WORD; end
      OP_LDH:  begin is_load = 1'b1; size = ACC_HALF; sign_ext = 1'b1; end
      OP_LDHU: begin is_load = 1'b1; size = ACC_HALF; end
      OP_LDB:  begin is_load = 1'b1; size = ACC_BYTE; sign_ext = 1'b1; end
      OP_LDBU: begin is_load = 1'b1; size = ACC_BYTE; end
      OP_STW:  begin is_store = 1'b1; size = ACC_WORD; end
      OP_STH:  begin is_store = 1'b1; size = ACC_HALF; end
      OP_STB:  begin is_store = 1'b1; size = ACC_BYTE; end
      default: ;
    endcase
  end

  always_comb begin
    unique case (size)
      ACC_WORD: misaligned = |ea[1:0];
      ACC_HALF: misaligned = ea[0];
      default:  misaligned = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e           size,
  input  logic [1:0]          lane_off,
  input  logic [DATA_W-1:0]   src,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] be
);
  localparam int LANES = DATA_W / 8;
  localparam int HALFS = LANES / 2;

  logic [DATA_W-1:0] rep_byte;
  logic [DATA_W-1:0] rep_half;

  for (genvar g = 0; g < LANES; g++) begin : g_byte_rep
    assign rep_byte[g*8 +: 8] = src[7:0];
  end
  for (genvar g = 0; g < HALFS; g++) begin : g_half_rep
    assign rep_half[g*16 +: 16] = src[15:0];
  end

  always_comb begin
    unique case (size)
      ACC_HALF: begin
        wdata = rep_half;
        be    = lane_off[1] ? 4'b0011 : 4'b1100;
      end
      ACC_BYTE: begin
        wdata = rep_byte;
        be    = 4'b1000 >> lane_off;
      end
      default: begin
        wdata = src;
        be    = '1;
      end
    endcase
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  acc_size_e         size,
  input  logic              sign_ext,
  input  logic [1:0]        lane_off,
  output logic [DATA_W-1:0] value
);
  logic [15:0] half_sel;
  logic [7:0]  byte_sel;

  always_comb begin
    half_sel = lane_off[1] ? word[15:0] : word[31:16];
    unique case (lane_off)
      2'd0:    byte_sel = word[31:24];
      2'd1:    byte_sel = word[23:16];
      2'd2:    byte_sel = word[15:8];
      default: byte_sel = word[7:0];
    endcase
  end

  always_comb begin
    unique case (size)
      ACC_HALF: value = {{(DATA_W-16){sign_ext & half_sel[15]}}, half_sel};
      ACC_BYTE: value = {{(DATA_W-8){sign_ext & byte_sel[7]}}, byte_sel};
      default:  value = word;
    endcase
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int OP_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [OP_W-1:0]     req_op,
  input  logic [DATA_W-1:0]   req_base,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                rsp_valid,
  input  logic [DATA_W-1:0]   rsp_rdata,
  output logic [DATA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  output logic                mem_we,
  output logic                mem_re,
  output logic                misalign_exc,
  output logic                ld_valid,
  output logic [DATA_W-1:0]   ld_data
);
  localparam int BE_W = DATA_W / 8;

  // Reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  // Request decode and effective address
  logic [DATA_W-1:0] ea;
  logic              dec_load, dec_store, dec_sign, dec_mis;
  acc_size_e         dec_size;

  lsu_addr_gen #(.DATA_W(DATA_W), .OFF_W(OFF_W), .OP_W(OP_W)) u_addr (
    .op(req_op), .base(req_base), .offset(req_offset), .ea(ea),
    .is_load(dec_load), .is_store(dec_store), .size(dec_size),
    .sign_ext(dec_sign), .misaligned(dec_mis)
  );

  logic [DATA_W-1:0] st_wdata;
  logic [BE_W-1:0]   st_be;

  lsu_store_lane #(.DATA_W(DATA_W)) u_store (
    .size(dec_size), .lane_off(ea[1:0]), .src(req_wdata),
    .wdata(st_wdata), .be(st_be)
  );

  // Latched load context
  acc_size_e  ctx_size_q, ctx_size_d;
  logic       ctx_sign_q, ctx_sign_d;
  logic [1:0] ctx_off_q, ctx_off_d;
  logic [DATA_W-1:0] ld_value;

  lsu_load_extract #(.DATA_W(DATA_W)) u_load (
    .word(rsp_rdata), .size(ctx_size_q), .sign_ext(ctx_sign_q),
    .lane_off(ctx_off_q), .value(ld_value)
  );

  // Next-state logic
  logic              acc_en, addr_en, wdata_en, ctx_en, ldd_en;
  logic              we_d, re_d, exc_d;
  logic [BE_W-1:0]   be_d;

  always_comb begin
    acc_en     = req_valid & (dec_load | dec_store);
    addr_en    = acc_en;
    wdata_en   = req_valid & dec_store;
    exc_d      = acc_en & dec_mis;
    we_d       = req_valid & dec_store & ~dec_mis;
    re_d       = req_valid & dec_load & ~dec_mis;
    be_d       = we_d ? st_be : '0;
    ctx_en     = re_d;
    ctx_size_d = dec_size;
    ctx_sign_d = dec_sign;
    ctx_off_d  = ea[1:0];
    ldd_en     = rsp_valid;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_be       <= '0;
      mem_we       <= 1'b0;
      mem_re       <= 1'b0;
      misalign_exc <= 1'b0;
      ld_valid     <= 1'b0;
      ld_data      <= '0;
      ctx_size_q   <= ACC_WORD;
      ctx_sign_q   <= 1'b0;
      ctx_off_q    <= 2'd0;
    end else begin
      mem_we       <= we_d;
      mem_re       <= re_d;
      misalign_exc <= exc_d;
      mem_be       <= be_d;
      ld_valid     <= rsp_valid;
      if (addr_en)  mem_addr  <= ea;
      if (wdata_en) mem_wdata <= st_wdata;
      if (ldd_en)   ld_data   <= ld_value;
      if (ctx_en) begin
        ctx_size_q <= ctx_size_d;
        ctx_sign_q <= ctx_sign_d;
        ctx_off_q  <= ctx_off_d;
      end
    end
  end

  // R9
  mis_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    misalign_exc |-> (!mem_we && !mem_re && mem_be == '0));
  // R5
  we_re_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(mem_we && mem_re));
  // R2
  be_only_with_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we |-> ($countones(mem_be) inside {1, 2, 4}));
  // R6
  ld_follows_rsp_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |=> ld_valid);
  // R10
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> (!mem_we && !mem_re && !misalign_exc));
  // R10
  idle_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> $stable(mem_addr));
endmodule

// File: tb/tb_lsu_align_unit.sv
module tb_lsu_align_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  req_op;
  logic [31:0] req_base;
  logic [15:0] req_offset;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;
  logic        mem_we, mem_re, misalign_exc, ld_valid;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lsu_align_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_we(mem_we), .mem_re(mem_re),
    .misalign_exc(misalign_exc), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // Reference model state
  logic [31:0] e_addr = 0, e_wdata = 0, e_ldd = 0;
  logic [3:0]  e_be = 0;
  logic        e_we = 0, e_re = 0, e_exc = 0, e_ldv = 0;
  int          c_size = 4;   // bytes
  bit          c_sign = 0;
  int          c_off = 0;
  string       t_ctl = "R10", t_wd = "R2", t_ld = "R6";

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] extract(logic [31:0] w, int sz, bit sg, int off);
    logic [31:0] r;
    if (sz == 4) r = w;
    else if (sz == 2) begin
      r = (off >= 2) ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
      if (sg && r[15]) r[31:16] = 16'hFFFF;
    end else begin
      r = (w >> (8 * (3 - off))) & 32'hFF;
      if (sg && r[7]) r[31:8] = 24'hFFFFFF;
    end
    return r;
  endfunction

  task automatic model_step();
    logic [31:0] ea;
    int sz, off;
    bit ld, st, sg, mis;
    // load response uses context before any update this edge
    e_ldv = rsp_valid;
    if (rsp_valid) begin
      e_ldd = extract(rsp_rdata, c_size, c_sign, c_off);
      t_ld = (c_size == 4) ? "R6" : (c_size == 2) ? "R7" : "R8";
    end
    ld = req_valid && req_op >= 6'h30 && req_op <= 6'h34;
    st = req_valid && req_op >= 6'h35 && req_op <= 6'h37;
    sz = 4; sg = 0;
    case (req_op)
      6'h31: begin sz = 2; sg = 1; end
      6'h32: sz = 2;
      6'h33: begin sz = 1; sg = 1; end
      6'h34: sz = 1;
      6'h36: sz = 2;
      6'h37: sz = 1;
      default: ;
    endcase
    ea = req_base + {{16{req_offset[15]}}, req_offset};
    off = int'(ea[1:0]);
    mis = (sz == 4 && off != 0) || (sz == 2 && ea[0]);
    e_we = 0; e_re = 0; e_exc = 0; e_be = 0; t_ctl = "R10";
    if (ld || st) begin
      e_addr = ea;
      e_exc = mis;
      t_ctl = mis ? "R9" : "R5";
      if (st) begin
        t_wd = (sz == 4) ? "R2" : (sz == 2) ? "R3" : "R4";
        e_wdata = (sz == 4) ? req_wdata :
                  (sz == 2) ? {req_wdata[15:0], req_wdata[15:0]} :
                              {4{req_wdata[7:0]}};
        if (!mis) begin
          e_we = 1;
          e_be = (sz == 4) ? 4'hF : (sz == 2) ? ((off >= 2) ? 4'h3 : 4'hC)
                                              : (4'h8 >> off);
        end
      end else if (!mis) begin
        e_re = 1;
        c_size = sz; c_sign = sg; c_off = off;
      end
    end
  endtask

  task automatic compare_all();
    chk("R1", "mem_addr", mem_addr, e_addr);
    chk(t_wd, "mem_wdata", mem_wdata, e_wdata);
    chk(t_wd == "R2" && e_we ? "R2" : t_ctl, "mem_be", {28'h0, mem_be}, {28'h0, e_be});
    chk(t_ctl, "mem_we", {31'h0, mem_we}, {31'h0, e_we});
    chk(t_ctl, "mem_re", {31'h0, mem_re}, {31'h0, e_re});
    chk(t_ctl, "misalign_exc", {31'h0, misalign_exc}, {31'h0, e_exc});
    chk(t_ld, "ld_valid", {31'h0, ld_valid}, {31'h0, e_ldv});
    chk(t_ld, "ld_data", ld_data, e_ldd);
  endtask

  task automatic cyc(input bit v, input logic [5:0] op, input logic [31:0] b,
                     input logic [15:0] o, input logic [31:0] wd,
                     input bit rv, input logic [31:0] rd);
    @(negedge clk);
    req_valid = v; req_op = op; req_base = b; req_offset = o; req_wdata = wd;
    rsp_valid = rv; rsp_rdata = rd;
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    rst_n = 0; req_valid = 0; req_op = 0; req_base = 0; req_offset = 0;
    req_wdata = 0; rsp_valid = 0; rsp_rdata = 0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11", "mem_we", {31'h0, mem_we}, 0);
    chk("R11", "mem_re", {31'h0, mem_re}, 0);
    chk("R11", "misalign_exc", {31'h0, misalign_exc}, 0);
    chk("R11", "ld_valid", {31'h0, ld_valid}, 0);
    chk("R11", "mem_be", {28'h0, mem_be}, 0);
    chk("R11", "mem_addr", mem_addr, 0);
    chk("R11", "mem_wdata", mem_wdata, 0);
    chk("R11", "ld_data", ld_data, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 negative offset and address wrap
    cyc(1, 6'h30, 32'h0000_1000, 16'hFFFC, 0, 0, 0);
    cyc(1, 6'h30, 32'hFFFF_FFF0, 16'h0020, 0, 0, 0);
    // R2 word store, R3 halfword stores, R4 byte stores at every lane
    cyc(1, 6'h35, 32'h100, 16'h0, 32'hDEAD_BEEF, 0, 0);
    cyc(1, 6'h36, 32'h100, 16'h0, 32'h1234_A5C3, 0, 0);
    cyc(1, 6'h36, 32'h100, 16'h2, 32'h1234_5A3C, 0, 0);
    for (int k = 0; k < 4; k++) cyc(1, 6'h37, 32'h200, 16'(k), 32'h0000_00E7 + k, 0, 0);
    // R9 misaligned word and halfword, load and store
    cyc(1, 6'h35, 32'h100, 16'h2, 32'h5555_5555, 0, 0);
    cyc(1, 6'h36, 32'h101, 16'h0, 32'h6666_6666, 0, 0);
    cyc(1, 6'h31, 32'h103, 16'h0, 0, 0, 0);
    // R7 signed/unsigned halfword loads at both halves, R8 byte loads at every lane
    cyc(1, 6'h31, 32'h300, 16'h0, 0, 0, 0);
    cyc(0, 6'h00, 0, 0, 0, 1, 32'h8001_7FFE);
    cyc(1, 6'h32, 32'h302, 16'h0, 0, 0, 0);
    cyc(0, 6'h00, 0, 0, 0, 1, 32'h1234_F00D);
    for (int k = 0; k < 4; k++) begin
      cyc(1, 6'h33, 32'h400, 16'(k), 0, 0, 0);
      cyc(0, 6'h00, 0, 0, 0, 1, 32'h80F1_7F02);
      cyc(1, 6'h34, 32'h400, 16'(k), 0, 0, 0);
      cyc(0, 6'h00, 0, 0, 0, 1, 32'h80F1_7F02);
    end
    // R6 word load, response delayed by idle cycles
    cyc(1, 6'h30, 32'h500, 16'h4, 0, 0, 0);
    cyc(0, 6'h30, 32'hAAAA_AAAA, 16'h1, 0, 0, 0);
    cyc(0, 6'h00, 0, 0, 0, 1, 32'hCAFE_BABE);
    // R10 non-memory opcodes with req_valid high leave state untouched
    cyc(1, 6'h2E, 32'h9999_0000, 16'h10, 32'h1111_1111, 0, 0);
    cyc(1, 6'h38, 32'h7777_0000, 16'h10, 32'h2222_2222, 0, 0);
    // mixed random traffic, model compared on every clock
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      op = 6'h2C + 6'($urandom_range(0, 15));
      cyc(($urandom % 4) != 0, op, $urandom, 16'($urandom), $urandom,
          ($urandom % 3) == 0, $urandom);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule